// File: doc/BRIEF.md
# Memory Traffic Performance Monitor

This block sits beside a DRAM controller and counts what the controller reports. Four event counters track read operations, write operations, cycles spent in the active state and cycles spent in the idle state. A fifth counter tracks elapsed clock cycles. Software reaches the block through a small APB-style register interface. It can start and stop all counters together, choose which event counters take part, and read back every count.

When any counter wraps, the block records a sticky flag and freezes all counting. It also raises an interrupt, so that no counter is allowed to run past its range unnoticed. A single write-one-to-clear register zeroes individual counters, or all of them in the same cycle, and drops the matching flags. Clearing everything in one write keeps the time base aligned with the event counts.

Top module: `dram_perf_mon`

## Requirements
- R1: After reset, all counters, the enable mask and the flags are zero. Counting is stopped, `irq` is low and `prdata` is zero.
- R2: Writing offset 0x000 with bit 1 set stops counting. With bit 1 clear and bit 0 set, the write starts counting. When both bits are set, stop wins. Reading 0x000 returns the running state in bit 0.
- R3: Offset 0x004 bits 3:0 enable event counters 0 to 3. While running, event counter n adds one on each clock in which its enable bit and `evt_i[n]` are both high. Input bit 0 is the read strobe, bit 1 the write strobe, bit 2 the active level and bit 3 the idle level.
- R4: The time counter at offset 0x020 adds one on every clock while running, with no enable bit of its own.
- R5: Event counter n reads at offset 0x030 + 8·n. Every counter keeps its value while stopped.
- R6: A counter at its largest value that is incremented wraps to zero. The same edge sets its flag in status offset 0x008, and stops all counting. Bit n is the flag for event counter n and bit 31 the flag for the time counter.
- R7: A start request is ignored while any status flag is set.
- R8: Writing 1 to bit n (0 to 3) or bit 31 of offset 0x00C zeroes that counter and its flag. Writing 0x8000000F zeroes all five counters in one cycle. Offset 0x00C reads zero.
- R9: A clear that lands in the same cycle as a counting event wins: the counter reads zero after that edge.
- R10: `irq` is high exactly when any status flag is set, and it changes on the same edge as the flags.
- R11: Offset 0x3F4 reads the version 0x00020001 and offset 0x3F8 reads the identity 0x7E31A5C0. Writes to either have no effect.
- R12: A write takes effect at the edge where `psel`, `penable` and `pwrite` are all high. Read data is captured at the setup-phase edge and stays valid throughout the access phase. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Register interface select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| evt_i | input | 4 | Event inputs from the DRAM controller: read strobe, write strobe, active level, idle level |
| irq | output | 1 | Overflow interrupt, registered |

## Verification
Two operations can fall on the same edge: a software clear of a counter and an increment of that same counter. The bench provokes this by holding the event inputs high with all enables set, then issuing clear writes while the counters run. Both directed single-counter masks and random masks are used, under random event traffic. It judges the result against a cycle-level model in which a clear always beats the increment, and it reads the counters back after stopping. A second collision is between an overflow and a start request. This is covered by trying to restart after a forced wrap and checking that the running bit stays low.

// File: rtl/dram_perf_pkg.sv
package dram_perf_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_CFG    = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_CLR    = 12'h00C;
  localparam logic [ADDR_W-1:0] OFF_TIME   = 12'h020;
  localparam logic [ADDR_W-1:0] OFF_EVT0   = 12'h030;
  localparam int unsigned       EVT_STRIDE = 8;
  localparam logic [ADDR_W-1:0] OFF_VER    = 12'h3F4;
  localparam logic [ADDR_W-1:0] OFF_ID     = 12'h3F8;

  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned CTRL_STOP_BIT  = 1;
  localparam int unsigned TIME_FLAG_BIT  = 31;

  localparam logic [DATA_W-1:0] VERSION_VAL = 32'h0002_0001;
  localparam logic [DATA_W-1:0] IDENT_VAL   = 32'h7E31_A5C0;

  function automatic logic [ADDR_W-1:0] evt_offset(input int unsigned idx);
    return ADDR_W'(int'(OFF_EVT0) + int'(idx * EVT_STRIDE));
  endfunction
endpackage

// File: rtl/perf_counter.sv
module perf_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  // Wrap is only reported when the clear does not take this edge.
  assign wrap = inc & ~clr & (&count);

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/perf_apb_decode.sv
module perf_apb_decode
  import dram_perf_pkg::*;
#(
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned CNT_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [ADDR_W-1:0]        paddr,
  input  logic [DATA_W-1:0]        pwdata,
  input  logic                     run,
  input  logic [NUM_EVT-1:0]       cfg,
  input  logic [DATA_W-1:0]        status,
  input  logic [NUM_EVT*CNT_W-1:0] evt_cnt,
  input  logic [CNT_W-1:0]         time_cnt,
  output logic                     start_req,
  output logic                     stop_req,
  output logic                     cfg_we,
  output logic [NUM_EVT-1:0]       cfg_wdata,
  output logic [NUM_EVT-1:0]       clr_evt,
  output logic                     clr_time,
  output logic [DATA_W-1:0]        prdata
);
  logic              wr_acc, rd_setup, clr_hit;
  logic [DATA_W-1:0] rd_val;
  wire               unused_wdata = ^pwdata[DATA_W-2:NUM_EVT];

  assign wr_acc    = psel & penable & pwrite;
  assign rd_setup  = psel & ~penable & ~pwrite;
  assign clr_hit   = wr_acc && (paddr == OFF_CLR);
  assign start_req = wr_acc && (paddr == OFF_CTRL) && pwdata[CTRL_START_BIT];
  assign stop_req  = wr_acc && (paddr == OFF_CTRL) && pwdata[CTRL_STOP_BIT];
  assign cfg_we    = wr_acc && (paddr == OFF_CFG);
  assign cfg_wdata = pwdata[NUM_EVT-1:0];
  assign clr_evt   = clr_hit ? pwdata[NUM_EVT-1:0] : '0;
  assign clr_time  = clr_hit & pwdata[TIME_FLAG_BIT];

  always_comb begin
    rd_val = '0;
    case (paddr)
      OFF_CTRL: rd_val[0] = run;
      OFF_CFG:  rd_val[NUM_EVT-1:0] = cfg;
      OFF_STAT: rd_val = status;
      OFF_TIME: rd_val = DATA_W'(time_cnt);
      OFF_VER:  rd_val = VERSION_VAL;
      OFF_ID:   rd_val = IDENT_VAL;
      default: begin
        for (int n = 0; n < int'(NUM_EVT); n++) begin
          if (paddr == evt_offset(n)) rd_val = DATA_W'(evt_cnt[n*CNT_W +: CNT_W]);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rd_val;
  end
endmodule

// File: rtl/perf_ctrl.sv
module perf_ctrl
  import dram_perf_pkg::*;
#(
  parameter int unsigned NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_req,
  input  logic               stop_req,
  input  logic               cfg_we,
  input  logic [NUM_EVT-1:0] cfg_wdata,
  input  logic [NUM_EVT-1:0] clr_evt,
  input  logic               clr_time,
  input  logic [NUM_EVT-1:0] evt_wrap,
  input  logic               time_wrap,
  output logic               run,
  output logic [NUM_EVT-1:0] cfg,
  output logic [DATA_W-1:0]  status,
  output logic               irq
);
  logic [NUM_EVT-1:0] ev_flag, ev_flag_d;
  logic               t_flag, t_flag_d, any_wrap, any_flag, run_d;

  always_comb begin
    ev_flag_d = (ev_flag & ~clr_evt) | evt_wrap;
    t_flag_d  = (t_flag & ~clr_time) | time_wrap;
    any_wrap  = (|evt_wrap) | time_wrap;
    any_flag  = (|ev_flag) | t_flag;
    if (stop_req || any_wrap)       run_d = 1'b0;
    else if (start_req && !any_flag) run_d = 1'b1;
    else                            run_d = run;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      cfg     <= '0;
      ev_flag <= '0;
      t_flag  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      run     <= run_d;
      ev_flag <= ev_flag_d;
      t_flag  <= t_flag_d;
      irq     <= (|ev_flag_d) | t_flag_d;
      if (cfg_we) cfg <= cfg_wdata;
    end
  end

  always_comb begin
    status = '0;
    status[NUM_EVT-1:0]   = ev_flag;
    status[TIME_FLAG_BIT] = t_flag;
  end
endmodule

// File: rtl/dram_perf_mon.sv
module dram_perf_mon
  import dram_perf_pkg::*;
#(
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [DATA_W-1:0]  pwdata,
  output logic [DATA_W-1:0]  prdata,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               irq
);
  localparam int unsigned FLAT_W = NUM_EVT * CNT_W;

  logic               run, start_req, stop_req, cfg_we, clr_time, time_wrap;
  logic [NUM_EVT-1:0] cfg, cfg_wdata, clr_evt, evt_wrap;
  logic [DATA_W-1:0]  status;
  logic [FLAT_W-1:0]  evt_cnt;
  logic [CNT_W-1:0]   time_cnt;

  perf_apb_decode #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .run(run), .cfg(cfg), .status(status),
    .evt_cnt(evt_cnt), .time_cnt(time_cnt), .start_req(start_req),
    .stop_req(stop_req), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .clr_evt(clr_evt), .clr_time(clr_time), .prdata(prdata)
  );

  perf_ctrl #(.NUM_EVT(NUM_EVT)) u_ctrl (
    .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .clr_evt(clr_evt),
    .clr_time(clr_time), .evt_wrap(evt_wrap), .time_wrap(time_wrap),
    .run(run), .cfg(cfg), .status(status), .irq(irq)
  );

  for (genvar g = 0; g < int'(NUM_EVT); g++) begin : g_evt
    perf_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst),
      .inc(run & cfg[g] & evt_i[g]),
      .clr(clr_evt[g]),
      .count(evt_cnt[g*CNT_W +: CNT_W]),
      .wrap(evt_wrap[g])
    );
  end

  perf_counter #(.CNT_W(CNT_W)) u_time (
    .clk(clk), .rst(rst), .inc(run), .clr(clr_time),
    .count(time_cnt), .wrap(time_wrap)
  );
endmodule

// File: rtl/dram_perf_mon_chk.sv
module dram_perf_mon_chk
  import dram_perf_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic              run,
  input logic [DATA_W-1:0] status,
  input logic              irq,
  input logic [CNT_W-1:0]  time_cnt
);
  logic ctrl_wr, clr_time_wr;
  assign ctrl_wr     = psel & penable & pwrite & (paddr == OFF_CTRL);
  assign clr_time_wr = psel & penable & pwrite & (paddr == OFF_CLR) & pwdata[TIME_FLAG_BIT];

  assert_stop_wins_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && pwdata[CTRL_STOP_BIT]) |=> !run);

  assert_time_counts_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !clr_time_wr) |=> (time_cnt == $past(time_cnt) + CNT_W'(1)));

  assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr_time_wr) |=> $stable(time_cnt));

  assert_frozen_on_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (|status) |-> !run);

  assert_start_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && (|status)) |=> !run);

  assert_time_clear_R8: assert property (@(posedge clk) disable iff (rst)
    clr_time_wr |=> (time_cnt == '0) && !status[TIME_FLAG_BIT]);

  assert_irq_matches_R10: assert property (@(posedge clk) disable iff (rst)
    irq == (|status));
endmodule

bind dram_perf_mon dram_perf_mon_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/dram_perf_mon_bench.sv
module dram_perf_mon_bench;
  localparam int unsigned CNT_W = 10;
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic        clk = 1'b0, rst = 1'b1;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [3:0]  evt_i = '0;
  logic        irq;
  logic        ev_rand = 1'b0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  dram_perf_mon #(.NUM_EVT(4), .CNT_W(CNT_W)) u_dram_perf_mon (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .evt_i(evt_i), .irq(irq)
  );

  // Reference model built from the requirements
  logic [CNT_W-1:0] m_cnt [4];
  logic [CNT_W-1:0] m_tcnt;
  logic [3:0]       m_cfg, m_st;
  logic             m_tst, m_run, m_wr, m_ovf, m_flag_old;
  logic [31:0]      m_rd, m_clr;

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h000: return {31'b0, m_run};
      12'h004: return {28'b0, m_cfg};
      12'h008: return {m_tst, 27'b0, m_st};
      12'h020: return 32'(m_tcnt);
      12'h030: return 32'(m_cnt[0]);
      12'h038: return 32'(m_cnt[1]);
      12'h040: return 32'(m_cnt[2]);
      12'h048: return 32'(m_cnt[3]);
      12'h3F4: return 32'h0002_0001;
      12'h3F8: return 32'h7E31_A5C0;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < 4; n++) m_cnt[n] = '0;
      m_tcnt = '0; m_cfg = '0; m_st = '0; m_tst = 0; m_run = 0; m_rd = '0;
    end else begin
      m_wr = psel & penable & pwrite;
      if (psel && !penable && !pwrite) m_rd = exp_read(paddr);
      m_clr = (m_wr && paddr == 12'h00C) ? pwdata : 32'h0;
      m_flag_old = (|m_st) | m_tst;
      m_ovf = 0;
      for (int n = 0; n < 4; n++) begin
        if (m_clr[n]) begin m_cnt[n] = '0; m_st[n] = 0; end
        else if (m_run && m_cfg[n] && evt_i[n]) begin
          if (m_cnt[n] == MAXV) begin m_cnt[n] = '0; m_st[n] = 1; m_ovf = 1; end
          else m_cnt[n] = m_cnt[n] + 1'b1;
        end
      end
      if (m_clr[31]) begin m_tcnt = '0; m_tst = 0; end
      else if (m_run) begin
        if (m_tcnt == MAXV) begin m_tcnt = '0; m_tst = 1; m_ovf = 1; end
        else m_tcnt = m_tcnt + 1'b1;
      end
      if (m_ovf) m_run = 0;
      if (m_wr && paddr == 12'h000) begin
        if (pwdata[1]) m_run = 0;
        else if (pwdata[0] && !m_flag_old && !m_ovf) m_run = 1;
      end
      if (m_wr && paddr == 12'h004) m_cfg = pwdata[3:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (ev_rand) evt_i = 4'($urandom);
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    step(); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    step(); penable = 1;
    step(); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, input string tag, output logic [31:0] d);
    step(); psel = 1; penable = 0; pwrite = 0; paddr = a;
    step(); penable = 1;
    d = prdata;
    chk(tag, prdata, m_rd);
    step(); psel = 0; penable = 0;
  endtask

  task automatic read_all(input string tag);
    logic [31:0] d;
    apb_rd(12'h000, tag, d); apb_rd(12'h004, tag, d); apb_rd(12'h008, tag, d);
    apb_rd(12'h020, tag, d);
    for (int n = 0; n < 4; n++) apb_rd(12'(12'h030 + 8 * n), tag, d);
  endtask

  task automatic chk_irq(input string tag);
    chk(tag, {31'b0, irq}, {31'b0, (|m_st) | m_tst});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, held;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 prdata", prdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    read_all("R1 reset value");
    // R11 constants, writes ignored; R12 unmapped
    apb_rd(12'h3F4, "R11 version", d); chk("R11 version const", d, 32'h0002_0001);
    apb_rd(12'h3F8, "R11 ident", d);   chk("R11 ident const", d, 32'h7E31_A5C0);
    apb_wr(12'h3F4, 32'hFFFF_FFFF); apb_wr(12'h3F8, 32'h0);
    apb_rd(12'h3F4, "R11 version after write", d); chk("R11 version kept", d, 32'h0002_0001);
    apb_rd(12'h3F8, "R11 ident after write", d);   chk("R11 ident kept", d, 32'h7E31_A5C0);
    apb_rd(12'h100, "R12 unmapped", d); chk("R12 unmapped zero", d, 32'h0);
    // R2 start, stop, both
    apb_wr(12'h004, 32'hF);
    apb_wr(12'h000, 32'h1);
    apb_rd(12'h000, "R2 running", d); chk("R2 running bit", d, 32'h1);
    apb_wr(12'h000, 32'h3);
    apb_rd(12'h000, "R2 stop wins", d); chk("R2 stopped bit", d, 32'h0);
    // R3 R4 R5 random traffic
    ev_rand = 1;
    for (int it = 0; it < 8; it++) begin
      apb_wr(12'h004, 32'($urandom) & 32'hF);
      apb_wr(12'h00C, 32'h8000_000F);
      apb_wr(12'h000, 32'h1);
      idle(5 + int'($urandom % 60));
      apb_wr(12'h000, 32'h2);
      read_all("R3 R4 counts");
      apb_rd(12'h020, "R4 time", held);
      idle(10);
      apb_rd(12'h020, "R5 time held", d); chk("R5 time unchanged", d, held);
      apb_rd(12'h038, "R5 event held", d);
    end
    // R9 clear collides with counting
    ev_rand = 0; evt_i = 4'hF;
    apb_wr(12'h004, 32'hF);
    apb_wr(12'h00C, 32'h8000_000F);
    apb_wr(12'h000, 32'h1);
    idle(5);
    apb_wr(12'h00C, 32'h1);
    apb_wr(12'h000, 32'h2);
    apb_rd(12'h030, "R9 clear beats count", d);
    apb_rd(12'h038, "R9 neighbour", held);
    chk("R9 cleared counter lags", {31'b0, d < held}, 32'h1);
    ev_rand = 1;
    for (int it = 0; it < 12; it++) begin
      apb_wr(12'h000, 32'h1);
      idle(int'($urandom % 8));
      apb_wr(12'h00C, (32'($urandom) & 32'h8000_000F));
      apb_wr(12'h000, 32'h2);
      read_all("R9 random clear");
    end
    // R8 clear all
    apb_wr(12'h00C, 32'h8000_000F);
    for (int n = 0; n < 4; n++) begin
      apb_rd(12'(12'h030 + 8 * n), "R8 clear all", d); chk("R8 event zero", d, 32'h0);
    end
    apb_rd(12'h020, "R8 clear all time", d); chk("R8 time zero", d, 32'h0);
    apb_rd(12'h00C, "R8 clear reads zero", d); chk("R8 clear reg zero", d, 32'h0);
    // R6 R7 R10 event overflow
    ev_rand = 0; evt_i = 4'h8;
    apb_wr(12'h004, 32'h8);
    apb_wr(12'h000, 32'h1);
    idle(20);
    apb_wr(12'h00C, 32'h8000_0000);
    idle(1100);
    apb_rd(12'h008, "R6 status", d); chk("R6 event3 flag only", d & 32'h8000_000F, 32'h8);
    apb_rd(12'h000, "R6 frozen", d); chk("R6 stopped", d, 32'h0);
    chk("R10 irq high", {31'b0, irq}, 32'h1);
    chk_irq("R10 irq model");
    apb_rd(12'h020, "R6 time frozen", held);
    idle(6);
    apb_rd(12'h020, "R6 time still", d); chk("R6 time unchanged", d, held);
    apb_wr(12'h000, 32'h1);
    apb_rd(12'h000, "R7 start ignored", d); chk("R7 not running", d, 32'h0);
    apb_wr(12'h00C, 32'h8);
    apb_rd(12'h008, "R8 flag cleared", d); chk("R8 status zero", d, 32'h0);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
    apb_wr(12'h000, 32'h1);
    apb_rd(12'h000, "R7 start accepted", d); chk("R7 running", d, 32'h1);
    // R6 time overflow
    apb_wr(12'h004, 32'h0);
    apb_wr(12'h00C, 32'h8000_000F);
    idle(1100);
    apb_rd(12'h008, "R6 time status", d); chk("R6 time flag", d, 32'h8000_0000);
    chk_irq("R10 irq time flag");
    apb_wr(12'h00C, 32'h8000_0000);
    chk_irq("R10 irq cleared");
    read_all("R6 final");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule